// File: doc/BRIEF.md
# Completion Tag Tracker and Validator

This block sits on the receive side of a packet-based requester. It keeps a table of non-posted requests that are still waiting for completions, indexed by tag. When the local logic issues a request, the tracker records the request class (memory, I/O or configuration) and the number of bytes expected back. The tracker refuses a tag that is already in flight.

Each completion that arrives is checked against the table and against the endpoint's own identity. A completion that breaks a rule is marked as dropped and raises the unexpected-completion error. A completion that passes is marked as accepted. Successful completions reduce the outstanding byte count, and the tag is freed once the count reaches zero. A completion with any non-successful status frees the tag immediately.

A per-tag cycle counter frees a tag that has waited too long and raises the timeout error. All errors are single-cycle pulses on a shared three-bit vector. Verdicts and errors appear one clock after the completion is presented.

Top module: `cpl_tag_tracker`

## Requirements
- R1: A completion whose requester ID differs from `cfg_req_id` is dropped (`cpl_drop`=1, `err_vec[2]`=1) and the table is left unchanged.
- R2: A completion whose tag is greater than or equal to `cfg_tag_limit` is dropped with `err_vec[2]`=1. A request on such a tag sees `req_ready`=0.
- R3: A completion on a tag with no outstanding request is dropped with `err_vec[2]`=1.
- R4: For a request of kind I/O (2'd1) or configuration (2'd2), a completion with `cpl_len` other than 1 dword is dropped with `err_vec[2]`=1, and the tag stays outstanding. `cpl_len` is in dwords. A length of 1 is accepted.
- R5: A completion with status 3'b010 (configuration retry) is dropped with `err_vec[2]`=1 unless the request kind is configuration. For a configuration request it is accepted and retires the tag.
- R6: An accepted completion whose status is not 3'b000 (successful) gives `cpl_ok`=1 and `cpl_retire`=1, with no error, and the tag becomes free.
- R7: A successful completion with `cpl_bytes` below the remaining count is accepted without retiring. One whose `cpl_bytes` equals the remaining count is accepted and retires the tag. Request kind 2'd0 is memory.
- R8: A successful completion whose `cpl_bytes` exceeds the remaining count is a length mismatch: `cpl_drop`=1, `err_vec[2]`=1, `cpl_retire`=1, and the tag becomes free.
- R9: With no completion, `err_vec[0]` pulses for one cycle exactly `cfg_tmo_limit`+1 clocks after the request handshake edge, and the tag is freed. A later completion on it is dropped as in R3.
- R10: An accepted, non-retiring completion restarts that tag's timer. While a tag is outstanding, `req_ready` is 0 for it.
- R11: After reset, all outputs are 0, the table is empty, and `req_ready` is 1 for any tag below `cfg_tag_limit`.
- R12: `cpl_ok`, `cpl_drop`, `cpl_retire` and `err_vec[2]` are registered and appear in the cycle after `cpl_valid`. `cpl_ok` and `cpl_drop` are never both high. `err_vec[1]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_req_id | input | ID_W | Endpoint's own bus/device/function identity |
| cfg_tag_limit | input | TAG_W+1 | Number of usable tags |
| cfg_tmo_limit | input | TMO_W | Timeout in clock cycles |
| req_valid | input | 1 | Request issue strobe |
| req_ready | output | 1 | Tag free and in range; request is recorded when both are high |
| req_tag | input | TAG_W | Tag of the issued request |
| req_kind | input | 2 | 0 memory, 1 I/O, 2 configuration |
| req_bytes | input | BC_W | Bytes expected back |
| cpl_valid | input | 1 | Completion header strobe |
| cpl_req_id | input | ID_W | Requester ID carried by the completion |
| cpl_tag | input | TAG_W | Tag carried by the completion |
| cpl_status | input | 3 | Completion status (0 successful, 2 retry) |
| cpl_len | input | LEN_W | Payload length in dwords |
| cpl_bytes | input | BC_W | Payload bytes carried |
| cpl_ok | output | 1 | Completion accepted |
| cpl_drop | output | 1 | Completion discarded |
| cpl_retire | output | 1 | Tag freed by this completion |
| err_vec | output | 3 | Bit 0 timeout, bit 1 unused, bit 2 unexpected completion |

## Verification
The bench targets the rule interactions that are easy to get wrong. A retry status is legal only for configuration requests, and a design that ignores the kind would accept it on memory reads. A length above one dword is illegal for I/O and configuration completions, and a design that applies this check to memory would drop good data. A dropped completion must leave the tag busy, so a design that frees the tag on any verdict shows a wrong `req_ready`. The timeout pulse is checked to the exact cycle, both from issue and after a partial completion restarts the timer. A late completion on a timed-out tag must be rejected.

// File: rtl/cpl_tag_pkg.sv
// Shared encodings for the completion tag tracker.
// Assumes: status and kind codes are fixed by the link protocol.
package cpl_tag_pkg;
    typedef enum logic [1:0] {
        KIND_MEM = 2'd0,
        KIND_IO  = 2'd1,
        KIND_CFG = 2'd2,
        KIND_RSV = 2'd3
    } req_kind_e;

    localparam logic [2:0] STS_SC  = 3'b000;
    localparam logic [2:0] STS_CRS = 3'b010;

    typedef struct packed {
        logic ok;
        logic drop;
        logic retire;
        logic unexp;
    } verdict_t;
endpackage

// File: rtl/cpl_tag_table.sv
// Outstanding request table: one entry per tag with valid, kind,
// remaining byte count and a wait counter.
// Assumes: alloc is only requested for an idle entry, upd only for a
// busy entry; an update in the same cycle as a timeout wins.
module cpl_tag_table #(
    parameter int NUM_TAGS = 32,
    parameter int TAG_W    = 5,
    parameter int BC_W     = 12,
    parameter int TMO_W    = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [TMO_W-1:0]               cfg_tmo_limit,
    input  logic                           alloc_en,
    input  logic [TAG_W-1:0]               alloc_tag,
    input  logic [1:0]                     alloc_kind,
    input  logic [BC_W-1:0]                alloc_bytes,
    input  logic                           upd_en,
    input  logic [TAG_W-1:0]               upd_tag,
    input  logic                           upd_retire,
    input  logic [BC_W-1:0]                upd_rem,
    output logic [NUM_TAGS-1:0]            valid_o,
    output logic [NUM_TAGS-1:0][1:0]       kind_o,
    output logic [NUM_TAGS-1:0][BC_W-1:0]  rem_o,
    output logic [NUM_TAGS-1:0]            tmo_o
);
    for (genvar i = 0; i < NUM_TAGS; i++) begin : g_ent
        logic             v_q;
        logic [1:0]       k_q;
        logic [BC_W-1:0]  r_q;
        logic [TMO_W-1:0] c_q;
        logic             hit_alloc;
        logic             hit_upd;
        logic             expired;

        assign hit_alloc = alloc_en && (alloc_tag == TAG_W'(i));
        assign hit_upd   = upd_en && (upd_tag == TAG_W'(i));
        assign expired   = v_q && (c_q == cfg_tmo_limit);

        // Entry state: allocate, update from a completion, or age/expire.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                k_q <= 2'd0;
                r_q <= '0;
                c_q <= '0;
            end else if (hit_alloc) begin
                v_q <= 1'b1;
                k_q <= alloc_kind;
                r_q <= alloc_bytes;
                c_q <= '0;
            end else if (hit_upd) begin
                v_q <= !upd_retire;
                r_q <= upd_rem;
                c_q <= '0;
            end else if (expired) begin
                v_q <= 1'b0;
                c_q <= '0;
            end else if (v_q) begin
                c_q <= c_q + 1'b1;
            end
        end

        assign valid_o[i] = v_q;
        assign kind_o[i]  = k_q;
        assign rem_o[i]   = r_q;
        assign tmo_o[i]   = expired && !hit_upd;
    end
endmodule

// File: rtl/cpl_rules.sv
// Completion rule checker: purely combinational verdict for one
// completion header against the selected table entry.
// Assumes: ent_* already reflect the entry addressed by cpl_tag.
module cpl_rules
    import cpl_tag_pkg::*;
#(
    parameter int ID_W  = 16,
    parameter int TAG_W = 5,
    parameter int BC_W  = 12,
    parameter int LEN_W = 10
) (
    input  logic             cpl_valid,
    input  logic [ID_W-1:0]  cpl_req_id,
    input  logic [TAG_W-1:0] cpl_tag,
    input  logic [2:0]       cpl_status,
    input  logic [LEN_W-1:0] cpl_len,
    input  logic [BC_W-1:0]  cpl_bytes,
    input  logic [ID_W-1:0]  cfg_req_id,
    input  logic [TAG_W:0]   cfg_tag_limit,
    input  logic             ent_valid,
    input  logic [1:0]       ent_kind,
    input  logic [BC_W-1:0]  ent_rem,
    output verdict_t         vd,
    output logic [BC_W-1:0]  new_rem
);
    logic id_bad, tag_bad, narrow, len_bad, crs_bad, reject;
    logic sc, over, fin;

    // Individual rule outcomes.
    always_comb begin
        id_bad  = (cpl_req_id != cfg_req_id);
        tag_bad = ({1'b0, cpl_tag} >= cfg_tag_limit);
        narrow  = (ent_kind == KIND_IO) || (ent_kind == KIND_CFG);
        len_bad = narrow && (cpl_len != LEN_W'(1));
        crs_bad = (cpl_status == STS_CRS) && (ent_kind != KIND_CFG);
        reject  = id_bad || tag_bad || !ent_valid || len_bad || crs_bad;
        sc      = (cpl_status == STS_SC);
        over    = sc && (cpl_bytes > ent_rem);
        fin     = sc && (cpl_bytes == ent_rem);
        new_rem = ent_rem - cpl_bytes;
    end

    // Combine the rules into one verdict.
    always_comb begin
        vd = '0;
        if (cpl_valid) begin
            if (reject) begin
                vd.drop  = 1'b1;
                vd.unexp = 1'b1;
            end else if (!sc) begin
                vd.ok     = 1'b1;
                vd.retire = 1'b1;
            end else if (over) begin
                vd.drop   = 1'b1;
                vd.unexp  = 1'b1;
                vd.retire = 1'b1;
            end else begin
                vd.ok     = 1'b1;
                vd.retire = fin;
            end
        end
    end
endmodule

// File: rtl/cpl_tag_tracker.sv
// Top: records issued requests, validates completions, times out
// stale tags and reports a registered verdict plus error pulses.
// Assumes: one request and one completion header per cycle at most.
module cpl_tag_tracker
    import cpl_tag_pkg::*;
#(
    parameter int NUM_TAGS = 32,
    parameter int TAG_W    = $clog2(NUM_TAGS),
    parameter int ID_W     = 16,
    parameter int BC_W     = 12,
    parameter int LEN_W    = 10,
    parameter int TMO_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ID_W-1:0]  cfg_req_id,
    input  logic [TAG_W:0]   cfg_tag_limit,
    input  logic [TMO_W-1:0] cfg_tmo_limit,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [1:0]       req_kind,
    input  logic [BC_W-1:0]  req_bytes,
    input  logic             cpl_valid,
    input  logic [ID_W-1:0]  cpl_req_id,
    input  logic [TAG_W-1:0] cpl_tag,
    input  logic [2:0]       cpl_status,
    input  logic [LEN_W-1:0] cpl_len,
    input  logic [BC_W-1:0]  cpl_bytes,
    output logic             cpl_ok,
    output logic             cpl_drop,
    output logic             cpl_retire,
    output logic [2:0]       err_vec
);
    logic [NUM_TAGS-1:0]           valid_v;
    logic [NUM_TAGS-1:0][1:0]      kind_v;
    logic [NUM_TAGS-1:0][BC_W-1:0] rem_v;
    logic [NUM_TAGS-1:0]           tmo_v;
    logic                          sel_valid;
    logic [1:0]                    sel_kind;
    logic [BC_W-1:0]               sel_rem;
    logic [BC_W-1:0]               new_rem;
    verdict_t                      vd;
    logic                          alloc_en;
    logic                          upd_en;
    logic                          ok_q, drop_q, retire_q;
    logic [2:0]                    err_q;

    // Request acceptance: tag idle and below the configured tag count.
    always_comb begin
        req_ready = !valid_v[req_tag] && ({1'b0, req_tag} < cfg_tag_limit);
        alloc_en  = req_valid && req_ready;
    end

    // Select the entry addressed by the completion.
    always_comb begin
        sel_valid = valid_v[cpl_tag];
        sel_kind  = kind_v[cpl_tag];
        sel_rem   = rem_v[cpl_tag];
        upd_en    = vd.ok || (vd.drop && vd.retire);
    end

    cpl_tag_table #(
        .NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W), .BC_W(BC_W), .TMO_W(TMO_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .cfg_tmo_limit(cfg_tmo_limit),
        .alloc_en(alloc_en), .alloc_tag(req_tag), .alloc_kind(req_kind),
        .alloc_bytes(req_bytes),
        .upd_en(upd_en), .upd_tag(cpl_tag), .upd_retire(vd.retire),
        .upd_rem(new_rem),
        .valid_o(valid_v), .kind_o(kind_v), .rem_o(rem_v), .tmo_o(tmo_v)
    );

    cpl_rules #(
        .ID_W(ID_W), .TAG_W(TAG_W), .BC_W(BC_W), .LEN_W(LEN_W)
    ) u_rules (
        .cpl_valid(cpl_valid), .cpl_req_id(cpl_req_id), .cpl_tag(cpl_tag),
        .cpl_status(cpl_status), .cpl_len(cpl_len), .cpl_bytes(cpl_bytes),
        .cfg_req_id(cfg_req_id), .cfg_tag_limit(cfg_tag_limit),
        .ent_valid(sel_valid), .ent_kind(sel_kind), .ent_rem(sel_rem),
        .vd(vd), .new_rem(new_rem)
    );

    // Register the verdict and the error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_q     <= 1'b0;
            drop_q   <= 1'b0;
            retire_q <= 1'b0;
            err_q    <= 3'b000;
        end else begin
            ok_q     <= vd.ok;
            drop_q   <= vd.drop;
            retire_q <= vd.retire;
            err_q    <= {vd.unexp, 1'b0, |tmo_v};
        end
    end

    assign cpl_ok     = ok_q;
    assign cpl_drop   = drop_q;
    assign cpl_retire = retire_q;
    assign err_vec    = err_q;
endmodule

// File: rtl/cpl_tag_tracker_chk.sv
// Property checker for cpl_tag_tracker, attached by bind.
// Assumes: configuration inputs are stable while traffic flows.
module cpl_tag_tracker_chk #(
    parameter int ID_W  = 16,
    parameter int TAG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ID_W-1:0]  cfg_req_id,
    input logic [TAG_W:0]   cfg_tag_limit,
    input logic             req_valid,
    input logic             req_ready,
    input logic [TAG_W-1:0] req_tag,
    input logic             cpl_valid,
    input logic [ID_W-1:0]  cpl_req_id,
    input logic [TAG_W-1:0] cpl_tag,
    input logic [2:0]       cpl_status,
    input logic             sel_valid,
    input logic [1:0]       sel_kind,
    input logic             cpl_ok,
    input logic             cpl_drop,
    input logic [2:0]       err_vec
);
    // R1
    id_mismatch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_req_id != cfg_req_id) |=> (cpl_drop && err_vec[2]));
    // R2
    tag_range_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && {1'b0, cpl_tag} >= cfg_tag_limit) |=> (cpl_drop && err_vec[2]));
    // R3
    idle_tag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !sel_valid) |=> cpl_drop);
    // R5
    crs_kind_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_status == 3'b010 && sel_kind != 2'd2) |=> cpl_drop);
    // R10
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (req_tag != $past(req_tag) || !req_ready));
    // R12
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpl_ok && cpl_drop));
    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpl_valid |=> (!cpl_ok && !cpl_drop && !err_vec[2]));
endmodule

bind cpl_tag_tracker cpl_tag_tracker_chk #(.ID_W(ID_W), .TAG_W(TAG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_req_id(cfg_req_id),
    .cfg_tag_limit(cfg_tag_limit), .req_valid(req_valid),
    .req_ready(req_ready), .req_tag(req_tag), .cpl_valid(cpl_valid),
    .cpl_req_id(cpl_req_id), .cpl_tag(cpl_tag), .cpl_status(cpl_status),
    .sel_valid(sel_valid), .sel_kind(sel_kind), .cpl_ok(cpl_ok),
    .cpl_drop(cpl_drop), .err_vec(err_vec)
);

// File: tb/cpl_tag_tracker_test.sv
module cpl_tag_tracker_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] MY_ID  = 16'h1A08;
    localparam logic [15:0] BAD_ID = 16'h1A09;
    localparam int TMO = 20;

    typedef struct packed {
        logic [1:0]  kind;
        logic [11:0] rbytes;
        logic        id_bad;
        logic [2:0]  sts;
        logic [9:0]  len;
        logic [11:0] cbytes;
        logic        e_ok;
        logic        e_drop;
        logic        e_ret;
    } vec_t;

    // kind, req bytes, bad id, status, len, cpl bytes, ok, drop, retire
    localparam vec_t VECS [12] = '{
        '{2'd0, 12'd64, 1'b0, 3'd0, 10'd16, 12'd64,  1'b1, 1'b0, 1'b1}, // R7 full
        '{2'd0, 12'd64, 1'b1, 3'd0, 10'd16, 12'd64,  1'b0, 1'b1, 1'b0}, // R1
        '{2'd1, 12'd4,  1'b0, 3'd0, 10'd1,  12'd4,   1'b1, 1'b0, 1'b1}, // R4 io ok
        '{2'd1, 12'd4,  1'b0, 3'd0, 10'd2,  12'd4,   1'b0, 1'b1, 1'b0}, // R4 io long
        '{2'd2, 12'd4,  1'b0, 3'd0, 10'd2,  12'd4,   1'b0, 1'b1, 1'b0}, // R4 cfg long
        '{2'd2, 12'd4,  1'b0, 3'd2, 10'd1,  12'd0,   1'b1, 1'b0, 1'b1}, // R5 cfg crs
        '{2'd0, 12'd64, 1'b0, 3'd2, 10'd1,  12'd0,   1'b0, 1'b1, 1'b0}, // R5 mem crs
        '{2'd1, 12'd4,  1'b0, 3'd2, 10'd1,  12'd0,   1'b0, 1'b1, 1'b0}, // R5 io crs
        '{2'd0, 12'd64, 1'b0, 3'd1, 10'd1,  12'd0,   1'b1, 1'b0, 1'b1}, // R6 UR
        '{2'd0, 12'd64, 1'b0, 3'd4, 10'd1,  12'd0,   1'b1, 1'b0, 1'b1}, // R6 CA
        '{2'd0, 12'd64, 1'b0, 3'd0, 10'd32, 12'd128, 1'b0, 1'b1, 1'b1}, // R8
        '{2'd0, 12'd64, 1'b0, 3'd0, 10'd8,  12'd32,  1'b1, 1'b0, 1'b0}  // R7 partial
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cfg_req_id;
    logic [5:0]  cfg_tag_limit;
    logic [15:0] cfg_tmo_limit;
    logic        req_valid, req_ready;
    logic [4:0]  req_tag;
    logic [1:0]  req_kind;
    logic [11:0] req_bytes;
    logic        cpl_valid;
    logic [15:0] cpl_req_id;
    logic [4:0]  cpl_tag;
    logic [2:0]  cpl_status;
    logic [9:0]  cpl_len;
    logic [11:0] cpl_bytes;
    logic        cpl_ok, cpl_drop, cpl_retire;
    logic [2:0]  err_vec;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpl_tag_tracker uut (
        .clk(clk), .rst_n(rst_n), .cfg_req_id(cfg_req_id),
        .cfg_tag_limit(cfg_tag_limit), .cfg_tmo_limit(cfg_tmo_limit),
        .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag),
        .req_kind(req_kind), .req_bytes(req_bytes),
        .cpl_valid(cpl_valid), .cpl_req_id(cpl_req_id), .cpl_tag(cpl_tag),
        .cpl_status(cpl_status), .cpl_len(cpl_len), .cpl_bytes(cpl_bytes),
        .cpl_ok(cpl_ok), .cpl_drop(cpl_drop), .cpl_retire(cpl_retire),
        .err_vec(err_vec)
    );

    task automatic chk(input bit good, input string req, input int act, input int exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // outputs packed as {ok, drop, retire, err_vec}
    task automatic chk_out(input string req, input logic [5:0] exp);
        logic [5:0] act;
        act = {cpl_ok, cpl_drop, cpl_retire, err_vec};
        chk(act == exp, req, int'(act), int'(exp));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0; cpl_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Called at a negedge; returns at the negedge after the handshake edge.
    task automatic issue(input logic [4:0] t, input logic [1:0] k, input logic [11:0] b, input string req);
        req_valid = 1'b1; req_tag = t; req_kind = k; req_bytes = b;
        #1 chk(req_ready == 1'b1, req, int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Called at a negedge; returns at the next negedge with the verdict visible.
    task automatic send(input logic [15:0] id, input logic [4:0] t, input logic [2:0] s,
                        input logic [9:0] l, input logic [11:0] b);
        cpl_valid = 1'b1; cpl_req_id = id; cpl_tag = t;
        cpl_status = s; cpl_len = l; cpl_bytes = b;
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    task automatic tag_free(input logic [4:0] t, input logic exp, input string req);
        req_tag = t;
        #1 chk(req_ready == exp, req, int'(req_ready), int'(exp));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        cfg_req_id = MY_ID; cfg_tag_limit = 6'd32; cfg_tmo_limit = 16'd1000;
        req_tag = '0; req_kind = '0; req_bytes = '0;
        cpl_req_id = '0; cpl_tag = '0; cpl_status = '0; cpl_len = '0; cpl_bytes = '0;
        do_reset();

        // R11: quiet outputs and empty table after reset
        chk_out("R11 reset outputs", 6'b000_000);
        tag_free(5'd0, 1'b1, "R11 tag0 free");
        tag_free(5'd31, 1'b1, "R11 tag31 free");

        // Vector table: one tag per vector
        for (int i = 0; i < 12; i++) begin
            vec_t v;
            v = VECS[i];
            @(negedge clk);
            issue(5'(i), v.kind, v.rbytes, "R10 issue ready");
            send(v.id_bad ? BAD_ID : MY_ID, 5'(i), v.sts, v.len, v.cbytes);
            chk_out($sformatf("R12 vector %0d verdict", i),
                    {v.e_ok, v.e_drop, v.e_ret, v.e_drop, 1'b0, 1'b0});
            tag_free(5'(i), v.e_ret, $sformatf("R10 vector %0d tag state", i));
        end

        // Fresh state for directed tests
        cfg_tmo_limit = 16'(TMO);
        do_reset();

        // R2: tag at the configured limit
        cfg_tag_limit = 6'd8;
        tag_free(5'd8, 1'b0, "R2 request tag over limit refused");
        tag_free(5'd7, 1'b1, "R2 request tag below limit ready");
        send(MY_ID, 5'd9, 3'd0, 10'd1, 12'd4);
        chk_out("R2 completion tag over limit", 6'b010_100);
        cfg_tag_limit = 6'd32;

        // R3: completion for a tag never issued
        send(MY_ID, 5'd3, 3'd0, 10'd1, 12'd4);
        chk_out("R3 idle tag", 6'b010_100);

        // R10: second issue on a busy tag refused, then complete it
        issue(5'd4, 2'd0, 12'd8, "R10 first issue");
        req_valid = 1'b1;
        tag_free(5'd4, 1'b0, "R10 busy tag refused");
        req_valid = 1'b0;
        send(MY_ID, 5'd4, 3'd0, 10'd2, 12'd8);
        chk_out("R7 single full completion", 6'b101_000);

        // R7: accumulation over three pieces
        issue(5'd2, 2'd0, 12'd100, "R7 issue");
        send(MY_ID, 5'd2, 3'd0, 10'd10, 12'd40);
        chk_out("R7 piece 1", 6'b100_000);
        send(MY_ID, 5'd2, 3'd0, 10'd10, 12'd40);
        chk_out("R7 piece 2", 6'b100_000);
        tag_free(5'd2, 1'b0, "R7 still busy");
        send(MY_ID, 5'd2, 3'd0, 10'd5, 12'd20);
        chk_out("R7 last piece retires", 6'b101_000);
        tag_free(5'd2, 1'b1, "R7 freed");

        // R9: timeout exactly TMO+1 cycles after handshake
        issue(5'd5, 2'd0, 12'd64, "R9 issue");
        for (int k = 1; k <= TMO; k++) begin
            @(negedge clk);
            if (k == TMO) chk(err_vec[0] == 1'b0, "R9 no early timeout", int'(err_vec[0]), 0);
        end
        @(negedge clk);
        chk(err_vec[0] == 1'b1, "R9 timeout pulse", int'(err_vec[0]), 1);
        @(negedge clk);
        chk(err_vec[0] == 1'b0, "R9 pulse one cycle", int'(err_vec[0]), 0);
        tag_free(5'd5, 1'b1, "R9 tag freed");
        send(MY_ID, 5'd5, 3'd0, 10'd16, 12'd64);
        chk_out("R9 late completion dropped", 6'b010_100);

        // R10: partial completion restarts the timer
        issue(5'd6, 2'd0, 12'd100, "R10 restart issue");
        repeat (15) @(negedge clk);
        send(MY_ID, 5'd6, 3'd0, 10'd10, 12'd40);
        chk_out("R10 partial accepted", 6'b100_000);
        begin
            bit seen = 1'b0;
            for (int k = 17; k <= 16 + TMO; k++) begin
                @(negedge clk);
                if (err_vec[0]) seen = 1'b1;
            end
            chk(seen == 1'b0, "R10 timer restarted", int'(seen), 0);
        end
        @(negedge clk);
        chk(err_vec[0] == 1'b1, "R9 timeout after restart", int'(err_vec[0]), 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule